// File: doc/BRIEF.md
# Relative Branch Condition Unit

This unit settles, for one branch instruction, whether the branch is taken and what the program counter becomes next. It takes a four-bit condition selector, the four arithmetic status flags (negative, zero, overflow, carry), the address of the instruction that follows the branch, and a signed displacement byte. It drives a taken flag and the next program counter.

A taken branch lands at the following instruction's address plus the sign-extended displacement, with the sum wrapping at the top of the address space. A branch that is not taken falls through to the following instruction. The selector covers the unconditional pair (always and never), the eight tests on a single flag, and the unsigned and signed relations that follow a compare. The arithmetic is combinational. A parameter places an optional register stage on the outputs, and that stage is on by default.

Top module: `rel_branch_unit`

## Requirements
- R1: The selector is 4 bits wide and the codes come in inverse pairs. Each odd code is taken exactly when the even code just below it is not taken, for the same flags. The flags input is ordered flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C.
- R2: Code 0 (always) is taken whatever the flags.
- R3: Code 1 (never) is never taken whatever the flags.
- R4: The single-flag codes are taken under these conditions: 4 when C=0, 5 when C=1, 6 when Z=0, 7 when Z=1, 8 when V=0, 9 when V=1, 10 when N=0, 11 when N=1. Unsigned higher-or-same uses code 4 and unsigned lower uses code 5.
- R5: Code 2 (unsigned higher) is taken when C OR Z is 0. Code 3 (unsigned lower-or-same) is taken when C OR Z is 1.
- R6: The signed codes are taken under these conditions: 12 (greater-or-equal) when N XOR V is 0, 13 (less-than) when N XOR V is 1, 14 (greater-than) when Z OR (N XOR V) is 0, and 15 (less-or-equal) when Z OR (N XOR V) is 1.
- R7: When the branch is taken, next_pc is next_addr plus the sign-extended displacement. A displacement of 0xFE therefore gives next_addr - 2, which is the address of a two-byte branch itself.
- R8: A displacement whose most significant bit is 0 moves forward by up to +127. One whose most significant bit is 1 moves backward by down to -128.
- R9: The target sum wraps modulo 65536 in both directions.
- R10: When the branch is not taken, next_pc equals next_addr.
- R11: With the register stage on (the default), the outputs show the result for the inputs sampled at the previous rising clock edge. An active-low reset clears taken to 0 and next_pc to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| cond_code | input | 4 | Branch condition selector |
| flags | input | 4 | Status flags N, Z, V, C (bit 3 down to bit 0) |
| next_addr | input | 16 | Address of the instruction after the branch |
| disp | input | 8 | Signed displacement |
| taken | output | 1 | Branch decision |
| next_pc | output | 16 | Next program counter |

## Verification
The condition decision and the target addition both act in every cycle. A fault in one can hide behind the other, for example a target that wraps past the top or the bottom of memory while the condition says not taken. The bench crosses every selector code with all sixteen flag combinations, drives wrap-prone addresses and both extreme displacements, and repeats inverse-pair codes on identical flags. A reference model predicts both outputs each cycle, and the bench compares them so that the fall-through address and the wrapped target are told apart.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
   typedef enum logic [3:0] {
      BR_ALWAYS = 4'd0,  BR_NEVER = 4'd1,
      BR_HI     = 4'd2,  BR_LS    = 4'd3,
      BR_CC     = 4'd4,  BR_CS    = 4'd5,
      BR_NE     = 4'd6,  BR_EQ    = 4'd7,
      BR_VC     = 4'd8,  BR_VS    = 4'd9,
      BR_PL     = 4'd10, BR_MI    = 4'd11,
      BR_GE     = 4'd12, BR_LT    = 4'd13,
      BR_GT     = 4'd14, BR_LE    = 4'd15
   } br_cond_e;

   // flag bundle, bit 3 down to bit 0
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   localparam int unsigned COND_W  = 4;
   localparam int unsigned N_PAIRS = 8;
endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
   import rbu_pkg::*;
(
   input  logic [COND_W-1:0] cond,
   input  flags_t            flg,
   output logic              hit
);
   localparam int unsigned SEL_W = COND_W - 1;

   // base test of each inverse pair; the odd member inverts it
   logic [N_PAIRS-1:0] base;

   always_comb begin
      base[0] = 1'b1;                            // always
      base[1] = ~(flg.c | flg.z);                // unsigned higher
      base[2] = ~flg.c;                          // carry clear
      base[3] = ~flg.z;                          // not equal
      base[4] = ~flg.v;                          // overflow clear
      base[5] = ~flg.n;                          // plus
      base[6] = ~(flg.n ^ flg.v);                // signed ge
      base[7] = ~(flg.z | (flg.n ^ flg.v));      // signed gt
   end

   logic [SEL_W-1:0] pair_sel;
   assign pair_sel = cond[COND_W-1:1];
   assign hit      = base[pair_sel] ^ cond[0];
endmodule

// File: rtl/rbu_target_add.sv
module rbu_target_add #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DISP_W = 8
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DISP_W-1:0] offset,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] off_ext;

   generate
      if (EXT_W > 0) begin : g_sext
         assign off_ext = {{EXT_W{offset[DISP_W-1]}}, offset};
      end else begin : g_same
         assign off_ext = offset[ADDR_W-1:0];
      end
   endgenerate

   // modular sum: carry out of the top bit is dropped
   assign target = base_addr + off_ext;
endmodule

// File: rtl/rbu_out_stage.sv
module rbu_out_stage #(
   parameter int unsigned DW      = 17,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
   import rbu_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DISP_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cond_code,
   input  logic [3:0]        flags,
   input  logic [ADDR_W-1:0] next_addr,
   input  logic [DISP_W-1:0] disp,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc
);
   localparam int unsigned OUT_W = ADDR_W + 1;

   initial begin
      if (DISP_W < 2)       $fatal(1, "displacement must be at least 2 bits");
      if (ADDR_W <= DISP_W) $fatal(1, "address must be wider than displacement");
   end

   logic              hit;
   logic [ADDR_W-1:0] tgt;
   logic [ADDR_W-1:0] pc_c;
   logic [OUT_W-1:0]  out_q;

   rbu_cond_eval u_cond (
      .cond (cond_code),
      .flg  (flags_t'(flags)),
      .hit  (hit)
   );

   rbu_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
      .base_addr (next_addr),
      .offset    (disp),
      .target    (tgt)
   );

   assign pc_c = hit ? tgt : next_addr;

   rbu_out_stage #(.DW(OUT_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hit, pc_c}),
      .q     (out_q)
   );

   assign taken   = out_q[ADDR_W];
   assign next_pc = out_q[ADDR_W-1:0];
endmodule

// File: rtl/rbu_chk.sv
module rbu_chk
   import rbu_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DISP_W = 8,
   parameter bit          LAT    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        cond_code,
   input logic [3:0]        flags,
   input logic [ADDR_W-1:0] next_addr,
   input logic [DISP_W-1:0] disp,
   input logic              taken,
   input logic [ADDR_W-1:0] next_pc
);
   logic              vld;
   logic [3:0]        d_code;
   flags_t            d_flg;
   logic [ADDR_W-1:0] d_addr;
   logic [DISP_W-1:0] d_disp;

   // align the inputs with the outputs they produced
   generate
      if (LAT) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld    <= 1'b0;
               d_code <= '0;
               d_flg  <= '0;
               d_addr <= '0;
               d_disp <= '0;
            end else begin
               vld    <= 1'b1;
               d_code <= cond_code;
               d_flg  <= flags_t'(flags);
               d_addr <= next_addr;
               d_disp <= disp;
            end
         end
      end else begin : g_now
         assign vld    = 1'b1;
         assign d_code = cond_code;
         assign d_flg  = flags_t'(flags);
         assign d_addr = next_addr;
         assign d_disp = disp;
      end
   endgenerate

   logic [DISP_W-1:0] minus_two;
   assign minus_two = {{(DISP_W-1){1'b1}}, 1'b0};

   // R2
   always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_code == BR_ALWAYS) |-> taken);

   // R3
   never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_code == BR_NEVER) |-> !taken);

   // R4
   equal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_code == BR_EQ) |-> (taken == d_flg.z));

   // R6
   signed_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && d_code == BR_GT) |-> (taken == !(d_flg.z || (d_flg.n != d_flg.v))));

   // R10
   fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !taken) |-> (next_pc == d_addr));

   // R7
   self_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && taken && d_disp == minus_two) |-> (next_pc == ADDR_W'(d_addr - ADDR_W'(2))));
endmodule

bind rel_branch_unit rbu_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LAT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cond_code (cond_code),
   .flags     (flags),
   .next_addr (next_addr),
   .disp      (disp),
   .taken     (taken),
   .next_pc   (next_pc)
);

// File: tb/rel_branch_unit_tb.sv
`timescale 1ns/1ps
module rel_branch_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  cond_code;
   logic [3:0]  flags;
   logic [15:0] next_addr;
   logic [7:0]  disp;
   logic        taken;
   logic [15:0] next_pc;

   int total = 0;
   int bad   = 0;

   int    q_taken[$];
   int    q_pc[$];
   string q_ttag[$];
   string q_ptag[$];

   always #2.5 clk = ~clk;

   rel_branch_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cond_code(cond_code), .flags(flags),
      .next_addr(next_addr), .disp(disp), .taken(taken), .next_pc(next_pc)
   );

   function automatic bit ref_taken(int code, bit n, bit z, bit v, bit c);
      case (code)
         0:  return 1'b1;
         1:  return 1'b0;
         2:  return !(c || z);
         3:  return c || z;
         4:  return !c;
         5:  return c;
         6:  return !z;
         7:  return z;
         8:  return !v;
         9:  return v;
         10: return !n;
         11: return n;
         12: return n == v;
         13: return n != v;
         14: return !z && (n == v);
         default: return z || (n != v);
      endcase
   endfunction

   task automatic apply(int code, int flg, int addr, int d);
      bit    tk;
      int    off, sum, pc;
      string tt, pt;
      cond_code = 4'(code);
      flags     = 4'(flg);
      next_addr = 16'(addr);
      disp      = 8'(d);
      tk  = ref_taken(code, flg[3], flg[2], flg[1], flg[0]);
      off = (d >= 128) ? d - 256 : d;
      sum = addr + off;
      if (tk) pc = ((sum % 65536) + 65536) % 65536;
      else    pc = addr;
      if (code == 0)       tt = "R2";
      else if (code == 1)  tt = "R3";
      else if (code <= 3)  tt = "R5";
      else if (code <= 11) tt = "R4";
      else                 tt = "R6";
      if (code % 2 == 1)   tt = {tt, "/R1"};
      if (!tk)                          pt = "R10";
      else if (sum < 0 || sum > 65535)  pt = "R9";
      else if (d == 8'hFE)              pt = "R7";
      else                              pt = "R8";
      q_taken.push_back(int'(tk));
      q_pc.push_back(pc);
      q_ttag.push_back(tt);
      q_ptag.push_back(pt);
   endtask

   // compare the outputs with the oldest prediction; called at negedge
   task automatic check_pending();
      int    et, ep;
      string tt, pt;
      if (q_taken.size() == 0) return;
      et = q_taken.pop_front();
      ep = q_pc.pop_front();
      tt = q_ttag.pop_front();
      pt = q_ptag.pop_front();
      total++;
      if (int'(taken) != et) begin
         bad++;
         $display("FAIL %s taken: actual=%0d expected=%0d", tt, taken, et);
      end
      total++;
      if (int'(next_pc) != ep) begin
         bad++;
         $display("FAIL %s next_pc: actual=%h expected=%h", pt, next_pc, ep[15:0]);
      end
   endtask

   task automatic step(int code, int flg, int addr, int d);
      @(negedge clk);
      check_pending();
      apply(code, flg, addr, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cond_code = 4'd0; flags = 4'hF; next_addr = 16'h1234; disp = 8'h10;
      repeat (3) @(negedge clk);
      // R11 reset state
      total++;
      if (taken !== 1'b0 || next_pc !== 16'h0000) begin
         bad++;
         $display("FAIL R11 reset: actual=%0d/%h expected=0/0000", taken, next_pc);
      end
      rst_n = 1'b1;
      apply(0, 0, 16'h1000, 8'h04);
      // every code against every flag combination
      for (int code = 0; code < 16; code++)
         for (int f = 0; f < 16; f++)
            step(code, f, 16'h2000 + code * 16 + f, (code * 37 + f * 11) % 256);
      // inverse pairs on identical flags (R1)
      for (int f = 0; f < 16; f++)
         for (int p = 0; p < 8; p++) begin
            step(2 * p, f, 16'h4400, 8'h22);
            step(2 * p + 1, f, 16'h4400, 8'h22);
         end
      // R7 self loop, R8 extremes, R9 wraps
      step(0, 0, 16'h1025, 8'hFE);
      step(7, 4, 16'h0102, 8'hFE);
      step(0, 0, 16'h3000, 8'h7F);
      step(0, 0, 16'h3000, 8'h80);
      step(0, 0, 16'hFFF0, 8'h20);
      step(0, 0, 16'h0005, 8'h80);
      step(0, 0, 16'hFFFF, 8'h01);
      step(0, 0, 16'h0000, 8'hFF);
      step(1, 0, 16'hFFF0, 8'h20);
      step(6, 4, 16'h0005, 8'h80);
      step(14, 0, 16'hFFFE, 8'h7F);
      step(15, 0, 16'h0001, 8'h80);
      // random mix
      for (int i = 0; i < 200; i++)
         step(int'($urandom % 16), int'($urandom % 16), int'($urandom % 65536),
              int'($urandom % 256));
      @(negedge clk);
      check_pending();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule